// File: doc/BRIEF.md
# Multicolumn Major-Location Cache Tag Unit

This block is the tag and placement engine of a 4-way set-associative cache that behaves like a direct-mapped cache in the common case. The set index picks a set in the usual way. Two bits of the tag then name one preferred way in that set, the major way. A lookup probes the major way first and answers in one cycle on a hit there. On a miss in the major way it spends one more cycle searching the other three ways, so the hit rate of a full 4-way cache is kept.

A new block is always written into its major way. If that way already holds another valid block, that block is moved into another way of the same set rather than dropped. An invalid way is preferred for this move. When the set is full, the way named by a per-major-way pointer is used, and the block held there is evicted and reported. Lookups and fills share a single engine. A fill takes priority and completes in one cycle, so any lookup accepted after it sees the new contents. Data storage and the memory side lie outside the block.

Top module: `mcol_cache_ctrl`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. `req_ready` and `fill_ready` are 1, and `resp_valid` and `fill_done` are 0.
- R2: An address is split from the least significant bit upward as follows: OFFSET_W offset bits, which are ignored; SET_W set bits; and the remaining tag bits. The major way is the value of the two lowest tag bits.
- R3: A lookup that hits in its major way gives `resp_valid`=1, `resp_hit`=1, `resp_major`=1 and `resp_way` equal to the major way, one cycle after the edge that accepted it.
- R4: A lookup that misses in its major way gives no response in the cycle after acceptance. One cycle later it gives `resp_valid`=1 and `resp_major`=0, with `resp_hit`=1 and `resp_way` equal to the matching non-major way, or `resp_hit`=0 if no way matches.
- R5: An accepted fill writes the new block into its major way. If that way was invalid, no other way changes and `fill_evict_valid` is 0.
- R6: If the major way holds a different valid block, that block moves to the lowest-numbered invalid non-major way. If no non-major way is invalid, it moves to the way named by the pointer of that major way. If the destination held a valid block, `fill_evict_valid`=1 and `fill_evict_addr` = {its tag, set, zero offset}.
- R7: Each pointer resets to (major way + 1) mod 4. Every relocation sets it to the destination way used.
- R8: A hit in a non-major way does not move the block, and repeated lookups of it keep answering from the same way through the search path.
- R9: A fill whose block is already present in any way of its set changes nothing, and reports `fill_done`=1 with `fill_evict_valid`=0.
- R10: A fill is accepted whenever the engine is idle and takes priority over a lookup in the same cycle: `req_ready` is 0 while `fill_valid` is 1. `fill_done` pulses one cycle after acceptance, and the next lookup sees the updated set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Lookup accepted on this edge if valid |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Block found |
| resp_way | output | 2 | Way holding the block |
| resp_major | output | 1 | Result came from the major-way probe |
| fill_valid | input | 1 | Fill request present |
| fill_addr | input | ADDR_W | Address of the block being installed |
| fill_ready | output | 1 | Fill accepted on this edge if valid |
| fill_done | output | 1 | Fill completed |
| fill_evict_valid | output | 1 | A valid block was dropped by the fill |
| fill_evict_addr | output | ADDR_W | Address of the dropped block |

## Verification
A major-way hit is due on the first falling edge after the accepting rising edge. The bench samples it there. A lookup that misses in its major way must still show `resp_valid` low at that falling edge, and its result is sampled one falling edge later. Fill results, including the evicted address, are due one cycle after acceptance and are sampled at the first falling edge. The bench's reference model applies the fill at that same point, so any later lookup is predicted against the updated set.

// File: rtl/mcol_pkg.sv
// Shared types for the multicolumn cache tag unit.
// Assumes exactly four ways, so two tag bits select the major way.
package mcol_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    typedef logic [WAY_W-1:0] way_t;
    typedef enum logic {ST_IDLE, ST_SEARCH} lk_state_t;
endpackage

// File: rtl/mcol_tag_store.sv
// Tag, valid and selected-location pointer storage for every set.
// Reads are combinational from one set. Writes are per way, and valid bits are only ever set.
// Assumes the caller never writes the same tag into two ways of one set.
module mcol_tag_store
    import mcol_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int TAG_W = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0][WAY_W-1:0]  rd_ptr,
    input  logic [WAYS-1:0]             wr_en,
    input  logic [WAYS-1:0][TAG_W-1:0]  wr_tag,
    input  logic                        ptr_we,
    input  way_t                        ptr_major,
    input  way_t                        ptr_val
);
    localparam int SETS = 1 << SET_W;

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] ptr_q   [SETS];

    // Read port: present one whole set.
    always_comb begin
        rd_tag   = tag_q[rd_set];
        rd_valid = valid_q[rd_set];
        rd_ptr   = ptr_q[rd_set];
    end

    // Tag array: written way by way, with no reset.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (wr_en[w]) tag_q[rd_set][w] <= wr_tag[w];
        end
    end

    // Valid bits and pointers: cleared or initialised at reset, then updated by fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int m = 0; m < WAYS; m++) ptr_q[s][m] <= WAY_W'(m + 1);
            end
        end else begin
            valid_q[rd_set] <= valid_q[rd_set] | wr_en;
            if (ptr_we) ptr_q[rd_set][ptr_major] <= ptr_val;
        end
    end

    // A pointer read from the store never names its own major way.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < WAYS; m++) begin
                assert_ptr_not_self_R7: assert (ptr_q[rd_set][m] != WAY_W'(m));
            end
        end
    end
endmodule

// File: rtl/mcol_way_match.sv
// Parallel tag comparators, one for each way of the presented set.
// Assumes invalid ways may hold any tag value.
module mcol_way_match
    import mcol_pkg::*;
#(
    parameter int TAG_W = 11
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           key_tag,
    output logic [WAYS-1:0]            hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        // One comparator: the way is valid and holds the key.
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == key_tag);
    end
endmodule

// File: rtl/mcol_place.sv
// Picks where the block displaced from a major way goes.
// Prefers the lowest invalid non-major way, otherwise the recorded pointer.
// Assumes the pointer never equals the major way.
module mcol_place
    import mcol_pkg::*;
(
    input  logic [WAYS-1:0] way_valid,
    input  way_t            major,
    input  way_t            ptr,
    output way_t            dest
);
    // Search from the top down so that the lowest free way wins.
    always_comb begin
        dest = ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w] && (WAY_W'(w) != major)) dest = WAY_W'(w);
        end
    end
endmodule

// File: rtl/mcol_cache_ctrl.sv
// Multicolumn cache tag unit: a one-cycle probe of the major way, then a one-cycle
// search of the other ways, and fills that always land in the major way and relocate
// the previous occupant. Assumes fill_valid is held until fill_ready.
module mcol_cache_ctrl
    import mcol_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int OFFSET_W = 2,
    parameter int SET_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [1:0]        resp_way,
    output logic              resp_major,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_ready,
    output logic              fill_done,
    output logic              fill_evict_valid,
    output logic [ADDR_W-1:0] fill_evict_addr
);
    localparam int TAG_W = ADDR_W - OFFSET_W - SET_W;

    lk_state_t               state_q;
    logic [SET_W-1:0]        lat_set;
    logic [TAG_W-1:0]        lat_tag;
    logic [SET_W-1:0]        k_set;
    logic [TAG_W-1:0]        k_tag;
    way_t                    k_major;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]         rd_valid;
    logic [WAYS-1:0][WAY_W-1:0] rd_ptr;
    logic [WAYS-1:0]         hit_vec;
    logic [WAYS-1:0]         other_hit;
    way_t                    other_way;
    way_t                    dest;
    logic [WAYS-1:0]         wr_en;
    logic [WAYS-1:0][TAG_W-1:0] wr_tag;
    logic                    ptr_we;
    logic                    fill_fire;
    logic                    req_fire;
    logic                    fill_dup;

    // Handshakes: a fill wins over a lookup, and both need the idle state.
    assign fill_ready = (state_q == ST_IDLE);
    assign req_ready  = (state_q == ST_IDLE) && !fill_valid;
    assign fill_fire  = fill_valid && fill_ready;
    assign req_fire   = req_valid && req_ready;

    // Key selection: the latched lookup while searching, else the fill, else the request.
    always_comb begin
        if (state_q == ST_SEARCH) begin
            k_set = lat_set;
            k_tag = lat_tag;
        end else if (fill_valid) begin
            k_set = fill_addr[OFFSET_W +: SET_W];
            k_tag = fill_addr[ADDR_W-1 -: TAG_W];
        end else begin
            k_set = req_addr[OFFSET_W +: SET_W];
            k_tag = req_addr[ADDR_W-1 -: TAG_W];
        end
        k_major = k_tag[WAY_W-1:0];
    end

    mcol_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) i_store (
        .clk(clk), .rst_n(rst_n), .rd_set(k_set),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_ptr(rd_ptr),
        .wr_en(wr_en), .wr_tag(wr_tag),
        .ptr_we(ptr_we), .ptr_major(k_major), .ptr_val(dest)
    );

    mcol_way_match #(.TAG_W(TAG_W)) i_match (
        .way_tag(rd_tag), .way_valid(rd_valid), .key_tag(k_tag), .hit_vec(hit_vec)
    );

    mcol_place i_place (
        .way_valid(rd_valid), .major(k_major), .ptr(rd_ptr[k_major]), .dest(dest)
    );

    assign fill_dup = |hit_vec;

    // Non-major search result: mask out the major way and encode the match.
    always_comb begin
        other_hit = hit_vec & ~(WAYS'(1) << k_major);
        other_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (other_hit[w]) other_way = WAY_W'(w);
        end
    end

    // Fill write command: new block into the major way, old occupant to dest.
    always_comb begin
        wr_en  = '0;
        wr_tag = '0;
        ptr_we = 1'b0;
        if (fill_fire && !fill_dup) begin
            wr_en[k_major]  = 1'b1;
            wr_tag[k_major] = k_tag;
            if (rd_valid[k_major]) begin
                wr_en[dest]  = 1'b1;
                wr_tag[dest] = rd_tag[k_major];
                ptr_we       = 1'b1;
            end
        end
    end

    // Lookup engine state and latched key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_set <= '0;
            lat_tag <= '0;
        end else if (state_q == ST_SEARCH) begin
            state_q <= ST_IDLE;
        end else if (req_fire && !hit_vec[k_major]) begin
            state_q <= ST_SEARCH;
            lat_set <= k_set;
            lat_tag <= k_tag;
        end
    end

    // Lookup response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= '0;
            resp_major <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            if (state_q == ST_SEARCH) begin
                resp_valid <= 1'b1;
                resp_hit   <= |other_hit;
                resp_way   <= other_way;
                resp_major <= 1'b0;
            end else if (req_fire && hit_vec[k_major]) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b1;
                resp_way   <= k_major;
                resp_major <= 1'b1;
            end
        end
    end

    // Fill completion and eviction report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_done        <= 1'b0;
            fill_evict_valid <= 1'b0;
            fill_evict_addr  <= '0;
        end else begin
            fill_done        <= fill_fire;
            fill_evict_valid <= fill_fire && !fill_dup && rd_valid[k_major] && rd_valid[dest];
            if (fill_fire) fill_evict_addr <= {rd_tag[dest], k_set, {OFFSET_W{1'b0}}};
        end
    end

    assert_major_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && hit_vec[k_major]) |=> (resp_valid && resp_hit && resp_major));

    assert_search_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !hit_vec[k_major]) |=> (!resp_valid ##1 (resp_valid && !resp_major)));

    assert_reloc_off_major_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_fire && !fill_dup && rd_valid[k_major]) |-> (dest != k_major));

    assert_no_duplicate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_fill_done_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire |=> fill_done);
endmodule

// File: tb/test_mcol_cache_ctrl.sv
module test_mcol_cache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid, resp_hit, resp_major;
    logic [1:0]  resp_way;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_addr = '0;
    logic        fill_ready, fill_done, fill_evict_valid;
    logic [15:0] fill_evict_addr;

    int n_chk = 0;
    int n_bad = 0;

    int mtag [8][4];
    bit mval [8][4];
    int mptr [8][4];

    mcol_cache_ctrl i_mcol_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_major(resp_major), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_ready(fill_ready), .fill_done(fill_done),
        .fill_evict_valid(fill_evict_valid), .fill_evict_addr(fill_evict_addr)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] mk(int s, int t, int off);
        return {11'(t), 3'(s), 2'(off)};
    endfunction

    task automatic chk(string rq, bit ok, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_lookup(logic [15:0] a, string rq);
        int s = int'(a[4:2]);
        int t = int'(a[15:5]);
        int m = t % 4;
        bit eh = 0;
        int ew = 0;
        bit em;
        logic [4:0] act, exp;
        em = mval[s][m] && mtag[s][m] == t;
        for (int w = 0; w < 4; w++)
            if (w != m && mval[s][w] && mtag[s][w] == t) begin eh = 1; ew = w; end
        @(negedge clk);
        req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        act = {resp_valid, resp_hit, resp_major, resp_way};
        if (em) begin
            exp = {3'b111, 2'(m)};
            chk({rq, " major-way hit"}, act == exp, 32'(act), 32'(exp));
        end else begin
            chk({rq, " no early response"}, resp_valid == 1'b0, 32'(resp_valid), 32'd0);
            @(negedge clk);
            act = {resp_valid, resp_hit, resp_major, eh ? resp_way : 2'b00};
            exp = {1'b1, eh, 1'b0, 2'(ew)};
            chk({rq, " search result"}, act == exp, 32'(act), 32'(exp));
        end
    endtask

    task automatic do_fill(logic [15:0] a, string rq);
        int s = int'(a[4:2]);
        int t = int'(a[15:5]);
        int m = t % 4;
        bit dup = 0;
        bit ev = 0;
        logic [15:0] ea = '0;
        logic [16:0] act, exp;
        for (int w = 0; w < 4; w++) if (mval[s][w] && mtag[s][w] == t) dup = 1;
        if (!dup) begin
            if (mval[s][m]) begin
                int d = mptr[s][m];
                for (int w = 3; w >= 0; w--) if (w != m && !mval[s][w]) d = w;
                ev = mval[s][d];
                ea = mk(s, mtag[s][d], 0);
                mtag[s][d] = mtag[s][m];
                mval[s][d] = 1;
                mptr[s][m] = d;
            end
            mtag[s][m] = t;
            mval[s][m] = 1;
        end
        @(negedge clk);
        fill_addr = a; fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        act = {fill_done, fill_evict_valid, fill_evict_valid ? fill_evict_addr : 16'h0};
        exp = {1'b1, ev, ea};
        chk(rq, act == exp, 32'(act), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin mval[s][w] = 0; mtag[s][w] = 0; mptr[s][w] = (w + 1) % 4; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk("R1 reset outputs", {req_ready, fill_ready, resp_valid, fill_done} == 4'b1100,
            32'({req_ready, fill_ready, resp_valid, fill_done}), 32'hC);
        do_lookup(mk(0, 5, 0), "R1 R4 miss after reset");
        // R5: fill into an empty major way, then a one-cycle hit
        do_fill(mk(0, 5, 0), "R5 fill empty major");
        do_lookup(mk(0, 5, 0), "R3 hit");
        do_lookup(mk(0, 5, 3), "R2 offset ignored");
        // R6: relocate to the lowest invalid way, then R8 no swap back
        do_fill(mk(0, 9, 0), "R6 relocate to free way");
        do_lookup(mk(0, 5, 0), "R4 R8 relocated block");
        do_lookup(mk(0, 5, 1), "R8 still not swapped");
        do_lookup(mk(0, 9, 0), "R3 new block in major");
        do_fill(mk(0, 2, 0), "R5 fill way2");
        do_fill(mk(0, 3, 0), "R5 fill way3");
        // R7: pointer updated by the earlier relocation, now used with the set full
        do_fill(mk(0, 13, 0), "R6 R7 full set uses updated pointer");
        do_lookup(mk(0, 5, 0), "R6 evicted block misses");
        do_lookup(mk(0, 9, 0), "R6 moved block found");
        // R7: reset pointer value on a full set
        do_fill(mk(1, 4, 0), "R5 set1 w0");
        do_fill(mk(1, 1, 0), "R5 set1 w1");
        do_fill(mk(1, 2, 0), "R5 set1 w2");
        do_fill(mk(1, 3, 0), "R5 set1 w3");
        do_fill(mk(1, 8, 0), "R7 reset pointer major+1");
        do_lookup(mk(1, 4, 0), "R7 moved into pointer way");
        // R9: duplicate fill is ignored
        do_fill(mk(0, 2, 0), "R9 duplicate fill");
        do_fill(mk(0, 9, 0), "R9 duplicate in non-major way");
        do_lookup(mk(0, 9, 0), "R9 block unchanged");
        // R10: fill wins over a simultaneous lookup
        @(negedge clk);
        fill_addr = mk(2, 6, 0); fill_valid = 1'b1;
        req_addr = mk(2, 6, 0); req_valid = 1'b1;
        #1;
        chk("R10 req_ready low during fill", req_ready == 1'b0, 32'(req_ready), 32'd0);
        mtag[2][2] = 6; mval[2][2] = 1;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        chk("R10 fill done, no response", {fill_done, resp_valid} == 2'b10,
            32'({fill_done, resp_valid}), 32'd2);
        do_lookup(mk(2, 6, 0), "R10 next lookup sees fill");
        // Random mix against the reference model
        void'($urandom(32'h5EED));
        for (int i = 0; i < 600; i++) begin
            int s = int'($urandom % 4) + 4;
            int t = int'($urandom % 16);
            int off = int'($urandom % 4);
            if ($urandom % 2 == 0) do_fill(mk(s, t, off), "R5 R6 R9 random fill");
            else do_lookup(mk(s, t, off), "R3 R4 random lookup");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule